// File: doc/BRIEF.md
# Register Operate Micro-Op Unit

This unit executes register-operate instructions for a processor with two 17-bit accumulators (A and B), a carry flag and a greater-than flag. Bit 16 of every word is the sign bit. The lower 16 bits form the body, and that body is the only part that shifts and rotates. The unit receives an operate word from the sequencer together with the current accumulators, the front-panel switch value and both flags. It produces the new value for the chosen accumulator, new flags and a skip indication for the program counter logic. Memory access and instruction fetch are handled elsewhere.

The operate word has three working groups. The step group combines any subset of these micro-operations in one word, applied in a fixed order: load from switches, clear, complement, sign-bit edits, increment or decrement, a single shift or rotate, and byte swap. The multi group shifts or rotates the body by 0 to 15 places, and arithmetic right shift is one of its options. The test group evaluates one skip condition on the values held before the word executes, then edits the flags and the register.

Each operation gives its result one cycle later. The result is presented as a one-cycle writeback strobe, and the skip pulse, when present, falls in that same cycle.

Top module: `opr_exec_unit`

## Requirements
- R1: While `rst` is high and after it falls, until the first operation, `wb_valid`, `skip`, `wb_to_a`, `wb_data`, `carry_out` and `gt_out` are all 0.
- R2: An operation accepted with `op_valid` at a clock edge gives `wb_valid`=1 for exactly the following cycle. Word bit 14 selects the accumulator (1 = A, 0 = B), and `wb_to_a` repeats it. The result is computed from that accumulator. When no operation arrives, `wb_data`, `wb_to_a` and both flags hold their values.
- R3: Word bits 16:15 = 00 selects the step group. Its bits take effect in this order: bit 0 load from `sw_val`, bit 1 clear, bit 2 one's complement, bit 3 clear bit 16, bit 4 complement bit 16. Clearing and then complementing bit 16 in one word therefore sets it.
- R4: Step bit 5 increments and step bit 6 decrements, both modulo 2^17 and both after the R3 operations. Neither changes the carry or GT flag.
- R5: Step bit 7 enables one single-place move of bits 15:0, and it takes place after R4. Bit 8 selects left (1) or right (0), and bit 9 selects rotate (1) or shift (0). A shift fills the vacated bit with 0 and discards the bit shifted out. Bit 16 is never changed by the move.
- R6: When step bits 7, 9 and 10 are all set, the rotate runs through a 17-position ring made of the carry and bits 15:0. The bit that leaves becomes the new carry, and the old carry enters the vacated end.
- R7: Step bit 11 exchanges bits 15:8 with bits 7:0. It is applied last in the step group and leaves bit 16 alone.
- R8: Word bits 16:15 = 01 selects the multi group. Bits 3:0 give the count n (0 to 15), and bits 6:4 give the kind: 0 logical right, 1 logical left, 2 rotate right, 3 rotate left, 4 arithmetic right (bit 15 is copied into the vacated bits). Kinds 5 to 7 and n = 0 leave the value unchanged. Bit 16 and both flags are always unchanged.
- R9: Word bits 16:15 = 10 selects the test group. Bits 3:0 choose the skip condition: 1 bit0=0, 2 bit15=0, 3 bit16=1, 4 bit16=0, 5 value zero, 6 value nonzero, 7 carry=1, 8 carry=0, 9 GT=1, 10 GT=0. Codes 0 and 11 to 15 never skip. The condition is evaluated on the values present before the word's own edits.
- R10: In the test group, bit 4 clears the carry and bit 5 then complements it. Bit 6 clears GT and bit 7 then sets it. Bit 8 clears the register and bit 9 then complements it.
- R11: `skip` is high only in a cycle where `wb_valid` is high, and only for a test-group word. Group 11 writes the selected register back unchanged, keeps both flags and never skips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operate word present this cycle |
| op_word | input | 17 | Operate word |
| acc_a | input | 17 | Current A accumulator |
| acc_b | input | 17 | Current B accumulator |
| sw_val | input | 17 | Switch register value |
| carry_in | input | 1 | Current carry flag |
| gt_in | input | 1 | Current greater-than flag |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_to_a | output | 1 | Writeback target, 1 = A, 0 = B |
| wb_data | output | 17 | New accumulator value |
| carry_out | output | 1 | New carry flag |
| gt_out | output | 1 | New greater-than flag |
| skip | output | 1 | Skip pulse, aligned with wb_valid |

## Verification
The hardest situations to reach are those where the order of the combined micro-operations decides the result. Examples are clearing bit 16 and then complementing it, incrementing before a byte swap, loading switches before complementing, and testing for zero in the same word that clears the register. Chance alone rarely makes these visible. The stimulus therefore drives directed words whose operand values make each ordering give a distinctive result. Examples include a body of 0x00FF that carries into the upper byte before the swap, and a carry ring of 0x8000 with the carry flag clear. After that, a long stream of random words and operands, with random idle gaps, is checked against a behavioural model on every clock.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int DATA_W = 17;
  localparam int LOW_W  = DATA_W - 1;
  localparam int BYTE_W = LOW_W / 2;
  localparam int CNT_W  = 4;
  localparam int COND_W = 4;
  localparam int KIND_W = 3;
  localparam int MAXN   = (1 << CNT_W) - 1;

  typedef enum logic [1:0] {
    GRP_STEP  = 2'd0,
    GRP_MULTI = 2'd1,
    GRP_TEST  = 2'd2,
    GRP_PASS  = 2'd3
  } grp_e;

  localparam logic [KIND_W-1:0] MK_LSR = 3'd0;
  localparam logic [KIND_W-1:0] MK_LSL = 3'd1;
  localparam logic [KIND_W-1:0] MK_ROR = 3'd2;
  localparam logic [KIND_W-1:0] MK_ROL = 3'd3;
  localparam logic [KIND_W-1:0] MK_ASR = 3'd4;

  localparam logic [COND_W-1:0] CC_LSB0  = 4'd1;
  localparam logic [COND_W-1:0] CC_TOP0  = 4'd2;
  localparam logic [COND_W-1:0] CC_NEG   = 4'd3;
  localparam logic [COND_W-1:0] CC_POS   = 4'd4;
  localparam logic [COND_W-1:0] CC_ZERO  = 4'd5;
  localparam logic [COND_W-1:0] CC_NZERO = 4'd6;
  localparam logic [COND_W-1:0] CC_CY    = 4'd7;
  localparam logic [COND_W-1:0] CC_NCY   = 4'd8;
  localparam logic [COND_W-1:0] CC_GT    = 4'd9;
  localparam logic [COND_W-1:0] CC_NGT   = 4'd10;

  typedef struct packed {
    logic ld_sw;
    logic clr;
    logic cpl;
    logic clr_sign;
    logic cpl_sign;
    logic inc;
    logic dec;
    logic mv_en;
    logic mv_left;
    logic mv_rot;
    logic mv_thru;
    logic swap;
  } step_t;

  typedef struct packed {
    logic [CNT_W-1:0]  count;
    logic [KIND_W-1:0] kind;
  } multi_t;

  typedef struct packed {
    logic c_clr;
    logic c_cpl;
    logic g_clr;
    logic g_set;
    logic r_clr;
    logic r_cpl;
  } tedit_t;

  typedef struct packed {
    grp_e              grp;
    logic              sel_a;
    step_t             st;
    multi_t            mu;
    tedit_t            te;
    logic [COND_W-1:0] cond;
  } ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  output ctl_t              ctl
);
  localparam int GRP_LSB = DATA_W - 2;
  localparam int SEL_BIT = DATA_W - 3;

  logic spare_unused;
  assign spare_unused = ^word[13:12];

  always_comb begin
    ctl          = '0;
    ctl.grp      = grp_e'(word[GRP_LSB +: 2]);
    ctl.sel_a    = word[SEL_BIT];
    ctl.st.ld_sw    = word[0];
    ctl.st.clr      = word[1];
    ctl.st.cpl      = word[2];
    ctl.st.clr_sign = word[3];
    ctl.st.cpl_sign = word[4];
    ctl.st.inc      = word[5];
    ctl.st.dec      = word[6];
    ctl.st.mv_en    = word[7];
    ctl.st.mv_left  = word[8];
    ctl.st.mv_rot   = word[9];
    ctl.st.mv_thru  = word[10];
    ctl.st.swap     = word[11];
    ctl.mu.count    = word[CNT_W-1:0];
    ctl.mu.kind     = word[CNT_W +: KIND_W];
    ctl.cond        = word[COND_W-1:0];
    ctl.te.c_clr    = word[4];
    ctl.te.c_cpl    = word[5];
    ctl.te.g_clr    = word[6];
    ctl.te.g_set    = word[7];
    ctl.te.r_clr    = word[8];
    ctl.te.r_cpl    = word[9];
  end
endmodule

// File: rtl/opr_skip_eval.sv
module opr_skip_eval
  import opr_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [DATA_W-1:0] val,
  input  logic              c_in,
  input  logic              g_in,
  output logic              hit
);
  always_comb begin
    case (cond)
      CC_LSB0:  hit = ~val[0];
      CC_TOP0:  hit = ~val[LOW_W-1];
      CC_NEG:   hit = val[DATA_W-1];
      CC_POS:   hit = ~val[DATA_W-1];
      CC_ZERO:  hit = (val == '0);
      CC_NZERO: hit = (val != '0);
      CC_CY:    hit = c_in;
      CC_NCY:   hit = ~c_in;
      CC_GT:    hit = g_in;
      CC_NGT:   hit = ~g_in;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
  import opr_pkg::*;
(
  input  grp_e              grp,
  input  step_t             st,
  input  multi_t            mu,
  input  tedit_t            te,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] sw,
  input  logic              c_in,
  input  logic              g_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              g_out
);
  // step group: fixed application order
  logic [DATA_W-1:0] step_res;
  logic              step_c;

  always_comb begin
    logic [DATA_W-1:0] s;
    logic [LOW_W-1:0]  lo;
    logic              sc;
    s = src;
    if (st.ld_sw)    s = sw;
    if (st.clr)      s = '0;
    if (st.cpl)      s = ~s;
    if (st.clr_sign) s[DATA_W-1] = 1'b0;
    if (st.cpl_sign) s[DATA_W-1] = ~s[DATA_W-1];
    if (st.inc)      s = s + DATA_W'(1);
    if (st.dec)      s = s - DATA_W'(1);
    lo = s[LOW_W-1:0];
    sc = c_in;
    if (st.mv_en) begin
      if (st.mv_left) begin
        if (st.mv_rot && st.mv_thru) {sc, lo} = {lo, sc};
        else if (st.mv_rot)          lo = {lo[LOW_W-2:0], lo[LOW_W-1]};
        else                         lo = {lo[LOW_W-2:0], 1'b0};
      end else begin
        if (st.mv_rot && st.mv_thru) {lo, sc} = {sc, lo};
        else if (st.mv_rot)          lo = {lo[0], lo[LOW_W-1:1]};
        else                         lo = {1'b0, lo[LOW_W-1:1]};
      end
    end
    if (st.swap) lo = {lo[BYTE_W-1:0], lo[LOW_W-1:BYTE_W]};
    step_res = {s[DATA_W-1], lo};
    step_c   = sc;
  end

  // multi group: chain of single-place stages, each gated by the count
  logic [LOW_W-1:0] mstage [MAXN+1];
  assign mstage[0] = src[LOW_W-1:0];

  for (genvar k = 0; k < MAXN; k++) begin : g_mstage
    logic [LOW_W-1:0] cur;
    logic [LOW_W-1:0] nxt;
    assign cur = mstage[k];
    always_comb begin
      case (mu.kind)
        MK_LSR:  nxt = {1'b0, cur[LOW_W-1:1]};
        MK_LSL:  nxt = {cur[LOW_W-2:0], 1'b0};
        MK_ROR:  nxt = {cur[0], cur[LOW_W-1:1]};
        MK_ROL:  nxt = {cur[LOW_W-2:0], cur[LOW_W-1]};
        MK_ASR:  nxt = {cur[LOW_W-1], cur[LOW_W-1:1]};
        default: nxt = cur;
      endcase
    end
    assign mstage[k+1] = (CNT_W'(k) < mu.count) ? nxt : cur;
  end

  // test group edits
  logic [DATA_W-1:0] test_res;
  logic              test_c;
  logic              test_g;

  always_comb begin
    test_res = src;
    if (te.r_clr) test_res = '0;
    if (te.r_cpl) test_res = ~test_res;
    test_c = c_in;
    if (te.c_clr) test_c = 1'b0;
    if (te.c_cpl) test_c = ~test_c;
    test_g = g_in;
    if (te.g_clr) test_g = 1'b0;
    if (te.g_set) test_g = 1'b1;
  end

  always_comb begin
    res   = src;
    c_out = c_in;
    g_out = g_in;
    case (grp)
      GRP_STEP: begin
        res   = step_res;
        c_out = step_c;
      end
      GRP_MULTI: res = {src[DATA_W-1], mstage[MAXN]};
      GRP_TEST: begin
        res   = test_res;
        c_out = test_c;
        g_out = test_g;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opr_exec_unit.sv
module opr_exec_unit
  import opr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_word,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [DATA_W-1:0] sw_val,
  input  logic              carry_in,
  input  logic              gt_in,
  output logic              wb_valid,
  output logic              wb_to_a,
  output logic [DATA_W-1:0] wb_data,
  output logic              carry_out,
  output logic              gt_out,
  output logic              skip
);
  ctl_t              ctl;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] res_n;
  logic              c_n;
  logic              g_n;
  logic              hit;

  opr_decode u_dec (
    .word (op_word),
    .ctl  (ctl)
  );

  assign src = ctl.sel_a ? acc_a : acc_b;

  opr_datapath u_dp (
    .grp   (ctl.grp),
    .st    (ctl.st),
    .mu    (ctl.mu),
    .te    (ctl.te),
    .src   (src),
    .sw    (sw_val),
    .c_in  (carry_in),
    .g_in  (gt_in),
    .res   (res_n),
    .c_out (c_n),
    .g_out (g_n)
  );

  opr_skip_eval u_skip (
    .cond (ctl.cond),
    .val  (src),
    .c_in (carry_in),
    .g_in (gt_in),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid  <= 1'b0;
      skip      <= 1'b0;
      wb_to_a   <= 1'b0;
      wb_data   <= '0;
      carry_out <= 1'b0;
      gt_out    <= 1'b0;
    end else begin
      wb_valid <= op_valid;
      skip     <= op_valid && (ctl.grp == GRP_TEST) && hit;
      if (op_valid) begin
        wb_to_a   <= ctl.sel_a;
        wb_data   <= res_n;
        carry_out <= c_n;
        gt_out    <= g_n;
      end
    end
  end

  // R2: strobe follows an accepted word by one cycle
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> wb_valid);
  p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!wb_valid && $stable(wb_data) && $stable(carry_out) && $stable(gt_out)));
  // R11: skip only alongside the strobe, and only for test words
  p_skip_with_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    skip |-> wb_valid);
  p_skip_test_only_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ctl.grp != GRP_TEST) |=> !skip);
  // R8: multi group keeps bit 16 and both flags
  p_multi_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ctl.grp == GRP_MULTI) |=>
      (wb_data[DATA_W-1] == $past(src[DATA_W-1]) && carry_out == $past(carry_in)
       && gt_out == $past(gt_in)));
  // R4: step words without a carry ring leave the carry and GT flags alone
  p_step_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ctl.grp == GRP_STEP && !(ctl.st.mv_en && ctl.st.mv_rot && ctl.st.mv_thru))
      |=> (carry_out == $past(carry_in) && gt_out == $past(gt_in)));
endmodule

// File: tb/sim_opr_exec_unit.sv
module sim_opr_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [16:0] op_word = '0;
  logic [16:0] acc_a = '0;
  logic [16:0] acc_b = '0;
  logic [16:0] sw_val = '0;
  logic        carry_in = 1'b0;
  logic        gt_in = 1'b0;
  logic        wb_valid, wb_to_a, carry_out, gt_out, skip;
  logic [16:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // expected outputs
  int e_valid = 0, e_sel = 0, e_data = 0, e_c = 0, e_g = 0, e_skip = 0;

  always #5 clk = ~clk;

  opr_exec_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .acc_a(acc_a), .acc_b(acc_b), .sw_val(sw_val), .carry_in(carry_in),
    .gt_in(gt_in), .wb_valid(wb_valid), .wb_to_a(wb_to_a), .wb_data(wb_data),
    .carry_out(carry_out), .gt_out(gt_out), .skip(skip)
  );

  function automatic logic [16:0] mk(int grp, int to_a, int low);
    return 17'((grp << 15) | (to_a << 14) | (low & 16'h3FFF));
  endfunction

  // behavioural model working on plain integers
  function automatic void model(input int w, a, b, sw, c, g,
                                output int r, rc, rg, rs);
    int grp, body, sgn, n, kind, cond, v;
    grp = (w >> 15) & 3;
    v   = ((w >> 14) & 1) ? a : b;
    rc = c; rg = g; rs = 0;
    if (grp == 0) begin
      if (w & 1)       v = sw;
      if (w & 2)       v = 0;
      if (w & 4)       v = v ^ 'h1FFFF;
      if (w & 8)       v = v & 'hFFFF;
      if (w & 16)      v = v ^ 'h10000;
      if (w & 32)      v = (v + 1) % 131072;
      if (w & 64)      v = (v + 131071) % 131072;
      sgn = v & 'h10000; body = v & 'hFFFF;
      if (w & 128) begin
        if ((w & 512) && (w & 1024)) begin
          int ring;
          ring = (rc << 16) | body;
          if (w & 256) ring = ((ring << 1) & 'h1FFFF) | (ring >> 16);
          else         ring = (ring >> 1) | ((ring & 1) << 16);
          rc = ring >> 16; body = ring & 'hFFFF;
        end else if (w & 512) begin
          if (w & 256) body = ((body << 1) & 'hFFFF) | (body >> 15);
          else         body = (body >> 1) | ((body & 1) << 15);
        end else begin
          if (w & 256) body = (body << 1) & 'hFFFF;
          else         body = body >> 1;
        end
      end
      if (w & 2048) body = ((body & 'hFF) << 8) | (body >> 8);
      r = sgn | body;
    end else if (grp == 1) begin
      n = w & 15; kind = (w >> 4) & 7;
      sgn = v & 'h10000; body = v & 'hFFFF;
      for (int i = 0; i < n; i++) begin
        case (kind)
          0: body = body >> 1;
          1: body = (body << 1) & 'hFFFF;
          2: body = (body >> 1) | ((body & 1) << 15);
          3: body = ((body << 1) & 'hFFFF) | (body >> 15);
          4: body = (body >> 1) | (body & 'h8000);
          default: ;
        endcase
      end
      r = sgn | body;
    end else if (grp == 2) begin
      cond = w & 15;
      case (cond)
        1: rs = ((v & 1) == 0);
        2: rs = ((v & 'h8000) == 0);
        3: rs = ((v & 'h10000) != 0);
        4: rs = ((v & 'h10000) == 0);
        5: rs = (v == 0);
        6: rs = (v != 0);
        7: rs = (c == 1);
        8: rs = (c == 0);
        9: rs = (g == 1);
        10: rs = (g == 0);
        default: rs = 0;
      endcase
      if (w & 16)  rc = 0;
      if (w & 32)  rc = 1 - rc;
      if (w & 64)  rg = 0;
      if (w & 128) rg = 1;
      if (w & 256) v = 0;
      if (w & 512) v = v ^ 'h1FFFF;
      r = v;
    end else begin
      r = v;
    end
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "wb_valid", int'(wb_valid), e_valid);
    cmp(tag, "skip", int'(skip), e_skip);
    cmp(tag, "wb_to_a", int'(wb_to_a), e_sel);
    cmp(tag, "wb_data", int'(wb_data), e_data);
    cmp(tag, "carry_out", int'(carry_out), e_c);
    cmp(tag, "gt_out", int'(gt_out), e_g);
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic do_op(bit v, logic [16:0] w, logic [16:0] a, logic [16:0] b,
                       logic [16:0] sw, bit c, bit g, string tag);
    int r, rc, rg, rs;
    op_valid = v; op_word = w; acc_a = a; acc_b = b; sw_val = sw;
    carry_in = c; gt_in = g;
    e_valid = v; e_skip = 0;
    if (v) begin
      model(int'(w), int'(a), int'(b), int'(sw), int'(c), int'(g), r, rc, rg, rs);
      e_sel = int'(w[14]); e_data = r; e_c = rc; e_g = rg; e_skip = rs;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 after reset");

    // R2: target select and idle hold
    do_op(1, mk(3, 0, 0), 17'h0AAAA, 17'h15555, 17'h0, 1, 0, "R2 B target");
    do_op(0, mk(0, 1, 2), 17'h1, 17'h2, 17'h0, 0, 1, "R2 idle hold");
    do_op(1, mk(3, 1, 0), 17'h1F00F, 17'h0, 17'h0, 0, 1, "R2 A target");
    // R3: ordering of load / clear / complement / sign edits
    do_op(1, mk(0, 1, 'b111), 17'h01234, 17'h0, 17'h0F0F0, 0, 0, "R3 ld clr cpl");
    do_op(1, mk(0, 0, 'b101), 17'h0, 17'h0, 17'h0F0F0, 0, 0, "R3 ld then cpl");
    do_op(1, mk(0, 1, 'b11000), 17'h01357, 17'h0, 17'h0, 0, 0, "R3 set sign");
    // R4: wrap, flags untouched
    do_op(1, mk(0, 1, 'h20), 17'h1FFFF, 17'h0, 17'h0, 1, 1, "R4 inc wrap");
    do_op(1, mk(0, 0, 'h40), 17'h0, 17'h0, 17'h0, 0, 1, "R4 dec wrap");
    // R5: single moves
    do_op(1, mk(0, 1, 'h180), 17'h18001, 17'h0, 17'h0, 0, 0, "R5 shl keeps b16");
    do_op(1, mk(0, 1, 'h080), 17'h10001, 17'h0, 17'h0, 1, 0, "R5 shr fill 0");
    do_op(1, mk(0, 1, 'h380), 17'h08000, 17'h0, 17'h0, 0, 0, "R5 rol");
    do_op(1, mk(0, 0, 'h280), 17'h00001, 17'h00001, 17'h0, 0, 0, "R5 ror");
    // R6: carry ring
    do_op(1, mk(0, 1, 'h780), 17'h08000, 17'h0, 17'h0, 0, 0, "R6 rol thru carry");
    do_op(1, mk(0, 1, 'h680), 17'h10000, 17'h0, 17'h0, 1, 0, "R6 ror thru carry");
    // R7: swap after increment
    do_op(1, mk(0, 1, 'h800), 17'h112AB, 17'h0, 17'h0, 0, 0, "R7 swap");
    do_op(1, mk(0, 1, 'h820), 17'h000FF, 17'h0, 17'h0, 0, 0, "R7 inc before swap");
    // R8: multi group
    do_op(1, mk(1, 1, 'h30), 17'h1ABCD, 17'h0, 17'h0, 1, 1, "R8 n zero");
    do_op(1, mk(1, 1, 'h3F), 17'h00003, 17'h0, 17'h0, 0, 0, "R8 rol 15");
    do_op(1, mk(1, 0, 'h44), 17'h0, 17'h08000, 17'h0, 0, 0, "R8 asr 4");
    do_op(1, mk(1, 1, 'h4F), 17'h17FFF, 17'h0, 17'h0, 1, 0, "R8 asr positive");
    do_op(1, mk(1, 1, 'h1F), 17'h1FFFF, 17'h0, 17'h0, 0, 0, "R8 shl 15");
    // R9: test before clear
    do_op(1, mk(2, 1, 'h105), 17'h0, 17'h0, 17'h0, 0, 0, "R9 zero then clear");
    do_op(1, mk(2, 1, 'h105), 17'h00010, 17'h0, 17'h0, 0, 0, "R9 nonzero then clear");
    do_op(1, mk(2, 0, 'h017), 17'h0, 17'h0, 17'h0, 1, 0, "R9 carry tested before clear");
    // R10: flag edit order
    do_op(1, mk(2, 1, 'h030), 17'h0, 17'h0, 17'h0, 0, 0, "R10 set carry");
    do_op(1, mk(2, 1, 'h0C0), 17'h0, 17'h0, 17'h0, 0, 0, "R10 clr then set gt");
    do_op(1, mk(2, 1, 'h300), 17'h05555, 17'h0, 17'h0, 0, 0, "R10 clr then cpl reg");
    // R11: pass group and no skip outside tests
    do_op(1, mk(3, 1, 'h3FFF), 17'h12345, 17'h0, 17'h0, 1, 1, "R11 pass group");
    do_op(1, mk(0, 1, 'h005), 17'h0, 17'h0, 17'h0, 0, 0, "R11 step no skip");

    for (int i = 0; i < 1500; i++) begin
      logic [16:0] w;
      string tag;
      w = 17'($urandom);
      case (w[16:15])
        2'd0: tag = "R3 R5 R6 R7 random step";
        2'd1: tag = "R8 random multi";
        2'd2: tag = "R9 R10 random test";
        default: tag = "R11 random pass";
      endcase
      do_op(($urandom % 4) != 0, w, 17'($urandom), 17'($urandom),
            17'($urandom), 1'($urandom), 1'($urandom), tag);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule